// File: doc/BRIEF.md
# Stereo Audio Sample Feeder

This block is the digital front end of a two-channel audio converter. It runs from an auxiliary clock. A programmable integer divider turns that clock into a converter clock enable. A second counter splits each run of 2**FRAME_LOG2 converter ticks (256 by default) into one audio sample period. At the end of every sample period the block puts out one unsigned 16-bit word per channel on two registered parallel outputs. At the same moment it raises a one-cycle valid pulse.

A processor-side write port fills one holding register per channel. Each holding register has a full flag. A sample that has been put out empties its register. A channel that is still empty when the sample is due gets the value of a programmable fallback register, so an underrun produces a known level instead of a repeat or silence. A write to a register that is already full replaces its content and latches a sticky overflow flag. Software clears that flag by writing a one to the clear address.

Top module: `stereo_sample_feeder`

## Requirements
- R1: The write address map is: 0 sets the divider field (low DIV_W bits of the data); 1 sets the fallback word; 2 loads the left holding register; 3 loads the right holding register; 4 clears overflow flags (bit 0 left, bit 1 right). The converter tick rate is the auxiliary clock divided by (field + 1). A write to address 0 restarts the divider count.
- R2: `sample_valid` is high for exactly one auxiliary clock cycle per sample period. Consecutive pulses are 2**FRAME_LOG2 × (field + 1) auxiliary cycles apart.
- R3: A write to address 2 or 3 stores the word and sets that channel's full flag. The next valid pulse presents the word unchanged as an unsigned value and clears the flag, unless a new write lands in the same cycle.
- R4: When both holding registers are empty at a sample, both outputs carry the fallback word.
- R5: When only one channel is empty at a sample, only that channel carries the fallback word. The other channel carries its own data.
- R6: A write to a full holding register replaces its word and sets that channel's sticky overflow flag. A write to address 4 clears only the flags whose bits are one.
- R7: The sample outputs change only in the cycle in which `sample_valid` is high, and they hold between pulses.
- R8: Synchronous reset empties both holding registers and clears both overflow flags. It sets the fallback word and both outputs to mid-scale (0x8000 at 16 bits) and the divider field, the divider count and the sample counter to zero. `sample_valid` is low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Auxiliary clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| left_full | output | 1 | Left holding register holds unconsumed data |
| right_full | output | 1 | Right holding register holds unconsumed data |
| left_ovf | output | 1 | Sticky left overwrite flag |
| right_ovf | output | 1 | Sticky right overwrite flag |
| sample_valid | output | 1 | One-cycle pulse marking new output samples |
| left_sample | output | DATA_W | Left channel sample |
| right_sample | output | DATA_W | Right channel sample |

## Verification
The bench builds the block with a 3-bit divider field and FRAME_LOG2 = 3, so a sample period is 8 converter ticks. This short period lets the bench sweep all eight divider settings and measure each period against 8 × (field + 1) in a few hundred cycles. It also checks output stability on every cycle between pulses. The short period leaves room to walk data patterns, including both extreme codes, through both channels. It also leaves room to cover single-sided and two-sided underruns and the overwrite and selective-clear paths.

// File: rtl/feeder_pkg.sv
package feeder_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_DFLT  = 3'd1,
    REG_LEFT  = 3'd2,
    REG_RIGHT = 3'd3,
    REG_CLR   = 3'd4
  } reg_addr_e;

  localparam int NUM_CH = 2;
  localparam int CH_L   = 0;
  localparam int CH_R   = 1;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] ratio,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == ratio);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
  parameter int FRAME_LOG2 = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic frame_end
);
  logic [FRAME_LOG2-1:0] pos_q;

  assign frame_end = tick && (pos_q == {FRAME_LOG2{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (tick) begin
      pos_q <= pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/channel_slot.sv
module channel_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              consume,
  input  logic              clr_ovf,
  output logic [DATA_W-1:0] word,
  output logic              full,
  output logic              ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      full <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (load) begin
        word <= load_data;
      end
      if (load) begin
        full <= 1'b1;
      end else if (consume) begin
        full <= 1'b0;
      end
      if (load && full && !consume) begin
        ovf <= 1'b1;
      end else if (clr_ovf) begin
        ovf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stereo_sample_feeder.sv
module stereo_sample_feeder
  import feeder_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DIV_W      = 7,
  parameter int FRAME_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              left_full,
  output logic              right_full,
  output logic              left_ovf,
  output logic              right_ovf,
  output logic              sample_valid,
  output logic [DATA_W-1:0] left_sample,
  output logic [DATA_W-1:0] right_sample
);
  localparam logic [DATA_W-1:0] MID_SCALE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DIV_W-1:0]  ratio_q;
  logic [DATA_W-1:0] dflt_q;
  logic              ctrl_wr;
  logic              tick;
  logic              frame_end;

  logic [DATA_W-1:0] slot_word [NUM_CH];
  logic [DATA_W-1:0] out_q     [NUM_CH];
  logic [NUM_CH-1:0] slot_full;
  logic [NUM_CH-1:0] slot_ovf;

  assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= '0;
      dflt_q  <= MID_SCALE;
    end else if (wr_en) begin
      if (wr_addr == REG_CTRL) ratio_q <= wr_data[DIV_W-1:0];
      if (wr_addr == REG_DFLT) dflt_q  <= wr_data;
    end
  end

  tick_divider #(.DIV_W(DIV_W)) div_i (
    .clk     (clk),
    .rst     (rst),
    .restart (ctrl_wr),
    .ratio   (ratio_q),
    .tick    (tick)
  );

  frame_counter #(.FRAME_LOG2(FRAME_LOG2)) frame_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .frame_end (frame_end)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [2:0] SLOT_ADDR = (ch == CH_L) ? REG_LEFT : REG_RIGHT;
    logic load;
    logic clr;

    assign load = wr_en && (wr_addr == SLOT_ADDR);
    assign clr  = wr_en && (wr_addr == REG_CLR) && wr_data[ch];

    channel_slot #(.DATA_W(DATA_W)) slot_i (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .load_data (wr_data),
      .consume   (frame_end),
      .clr_ovf   (clr),
      .word      (slot_word[ch]),
      .full      (slot_full[ch]),
      .ovf       (slot_ovf[ch])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[ch] <= MID_SCALE;
      end else if (frame_end) begin
        out_q[ch] <= slot_full[ch] ? slot_word[ch] : dflt_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sample_valid <= 1'b0;
    else     sample_valid <= frame_end;
  end

  assign left_sample  = out_q[CH_L];
  assign right_sample = out_q[CH_R];
  assign left_full    = slot_full[CH_L];
  assign right_full   = slot_full[CH_R];
  assign left_ovf     = slot_ovf[CH_L];
  assign right_ovf    = slot_ovf[CH_R];
endmodule

// File: rtl/feeder_checker.sv
module feeder_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              left_full,
  input logic              right_full,
  input logic              left_ovf,
  input logic              right_ovf,
  input logic              sample_valid,
  input logic [DATA_W-1:0] left_sample,
  input logic [DATA_W-1:0] right_sample
);
  // R2
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  // R7
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> ($stable(left_sample) && $stable(right_sample)));

  // R3
  left_fill_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(left_full) |-> $past(wr_en && wr_addr == 3'd2));

  // R3
  right_fill_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(right_full) |-> $past(wr_en && wr_addr == 3'd3));

  // R3
  left_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !$past(wr_en && wr_addr == 3'd2)) |-> !left_full);

  // R6
  left_ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(left_ovf) |-> $past(left_full && wr_en && wr_addr == 3'd2));

  // R6
  right_ovf_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(right_ovf) |-> $past(wr_en && wr_addr == 3'd4 && wr_data[1]));
endmodule

bind stereo_sample_feeder feeder_checker #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .left_full    (left_full),
  .right_full   (right_full),
  .left_ovf     (left_ovf),
  .right_ovf    (right_ovf),
  .sample_valid (sample_valid),
  .left_sample  (left_sample),
  .right_sample (right_sample)
);

// File: tb/stereo_sample_feeder_tb.sv
module stereo_sample_feeder_tb_top;
  localparam int DATA_W     = 16;
  localparam int DIV_W      = 3;
  localparam int FRAME_LOG2 = 3;
  localparam int FRAME      = 1 << FRAME_LOG2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              left_full, right_full, left_ovf, right_ovf, sample_valid;
  logic [DATA_W-1:0] left_sample, right_sample;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  stereo_sample_feeder #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .FRAME_LOG2(FRAME_LOG2)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .left_full(left_full), .right_full(right_full),
    .left_ovf(left_ovf), .right_ovf(right_ovf),
    .sample_valid(sample_valid),
    .left_sample(left_sample), .right_sample(right_sample)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sample_valid) return;
    end
    check("R2 valid pulse timeout", 32'd0, 32'd1);
  endtask

  // returns cycles until next pulse, checking outputs hold meanwhile (R7)
  task automatic measure_period(output int n);
    logic [DATA_W-1:0] l0, r0;
    l0 = left_sample; r0 = right_sample;
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      n++;
      if (sample_valid) return;
      if (left_sample !== l0 || right_sample !== r0) begin
        check("R7 outputs hold", {left_sample, right_sample}, {l0, r0});
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int per;
    logic [DATA_W-1:0] lv, rv;
    logic [DATA_W-1:0] dvals [4];
    dvals[0] = 16'h0000; dvals[1] = 16'hFFFF; dvals[2] = 16'h1234; dvals[3] = 16'h8001;

    repeat (4) @(negedge clk);
    check("R8 valid low in reset", {31'd0, sample_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check("R8 flags", {28'd0, left_full, right_full, left_ovf, right_ovf}, 32'd0);
    check("R8 left mid-scale", {16'd0, left_sample}, 32'h8000);
    check("R8 right mid-scale", {16'd0, right_sample}, 32'h8000);

    // R1 R2: all divider settings
    for (int dv = 0; dv < (1 << DIV_W); dv++) begin
      reg_write(3'd0, DATA_W'(dv));
      wait_valid();
      measure_period(per);
      check($sformatf("R1 R2 period div=%0d", dv), per, FRAME * (dv + 1));
      measure_period(per);
      check($sformatf("R2 period repeat div=%0d", dv), per, FRAME * (dv + 1));
    end

    reg_write(3'd0, 16'd1);
    wait_valid();
    // R8 fallback still mid-scale after reset with no data
    check("R8 R4 first fallback left", {16'd0, left_sample}, 32'h8000);

    // R4 fallback sweep
    foreach (dvals[k]) begin
      reg_write(3'd1, dvals[k]);
      wait_valid();
      check("R4 left fallback", {16'd0, left_sample}, {16'd0, dvals[k]});
      check("R4 right fallback", {16'd0, right_sample}, {16'd0, dvals[k]});
    end

    // R3 data patterns
    for (int k = 0; k < 8; k++) begin
      lv = (k == 7) ? 16'hFFFF : DATA_W'(k * 16'h2492);
      rv = ~lv;
      wait_valid();
      reg_write(3'd2, lv);
      reg_write(3'd3, rv);
      check("R3 full after write", {30'd0, left_full, right_full}, 32'd3);
      measure_period(per);
      check("R3 left data", {16'd0, left_sample}, {16'd0, lv});
      check("R3 right data", {16'd0, right_sample}, {16'd0, rv});
      check("R3 emptied", {30'd0, left_full, right_full}, 32'd0);
    end

    // R5 one-sided underrun
    reg_write(3'd1, 16'h5A5A);
    wait_valid();
    reg_write(3'd2, 16'h1111);
    wait_valid();
    check("R5 left own data", {16'd0, left_sample}, 32'h1111);
    check("R5 right fallback", {16'd0, right_sample}, 32'h5A5A);
    reg_write(3'd3, 16'h2222);
    wait_valid();
    check("R5 left fallback", {16'd0, left_sample}, 32'h5A5A);
    check("R5 right own data", {16'd0, right_sample}, 32'h2222);

    // R6 overwrite and sticky flag
    wait_valid();
    reg_write(3'd2, 16'hAAAA);
    check("R6 no ovf on first write", {30'd0, left_ovf, right_ovf}, 32'd0);
    reg_write(3'd2, 16'hBBBB);
    check("R6 left ovf set", {30'd0, left_ovf, right_ovf}, 32'd2);
    reg_write(3'd3, 16'hCCCC);
    reg_write(3'd3, 16'hDDDD);
    check("R6 both ovf set", {30'd0, left_ovf, right_ovf}, 32'd3);
    wait_valid();
    check("R6 left overwritten value", {16'd0, left_sample}, 32'hBBBB);
    check("R6 right overwritten value", {16'd0, right_sample}, 32'hDDDD);
    check("R6 ovf sticky", {30'd0, left_ovf, right_ovf}, 32'd3);
    reg_write(3'd4, 16'h0002);
    check("R6 clear right only", {30'd0, left_ovf, right_ovf}, 32'd2);
    reg_write(3'd4, 16'hFFFC);
    check("R6 zero bits keep flag", {30'd0, left_ovf, right_ovf}, 32'd2);
    reg_write(3'd4, 16'h0001);
    check("R6 clear left", {30'd0, left_ovf, right_ovf}, 32'd0);

    // R1 restart then R7 hold with data
    reg_write(3'd0, 16'd2);
    wait_valid();
    measure_period(per);
    check("R1 R7 period after restart", per, FRAME * 3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule